// File: doc/BRIEF.md
# Post-Update Load/Store Address Unit

This unit executes post-increment loads and stores for a 64-bit register machine. A decoder hands it one operation at a time: the access size, whether a load is signed, load or store, the offset form, the base register contents, the offset operand (an index register or a raw displacement field) and the store data. The unit issues exactly one memory request, and the address of that request is the base register value as it was, with no offset added. When the access has finished, the unit returns the new base value (base plus offset) for write-back. A load also returns its value, zero- or sign-extended to 64 bits.

The memory side uses a request handshake (`mem_req_valid`/`mem_req_ready`). Load data comes back on a separate `mem_rsp_valid` strobe. Operations enter through `op_valid`/`op_ready`, and `op_ready` is high only while the unit is idle.

The control state machine has four states. `IDLE` waits for an operation. `ISSUE` presents the memory request. `AWAIT` waits for load data. `REJECT` is a one-cycle state that flags an invalid form.

The transitions are:
- `IDLE` to `ISSUE` when an operation is accepted.
- `IDLE` to `REJECT` when a load names the same register as target and base.
- `ISSUE` to `IDLE` when a store is acknowledged.
- `ISSUE` to `AWAIT` when a load is acknowledged.
- `AWAIT` to `IDLE` when the response arrives.
- `REJECT` to `IDLE` unconditionally.

Top module: `postinc_ldst`

## Requirements
- R1: The memory request address equals the `op_base` value captured at acceptance, with no offset added.
- R2: With `op_form` = 0 (plain displacement), the new base is `op_base` plus `op_offset[15:0]` sign-extended; bits above 15 are ignored.
- R3: With `op_form` = 1 (scaled displacement), the new base is `op_base` plus the sign extension of `{op_offset[13:0], 2'b00}`; bits above 13 are ignored.
- R4: With `op_form` = 2 or 3 (indexed), the new base is `op_base` plus the full 64-bit `op_offset`.
- R5: `op_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An unsigned load returns the low bytes of `mem_rsp_rdata` with all upper bits zero. `op_signed` has no effect on byte and doubleword loads.
- R6: A signed halfword or word load sign-extends its top loaded bit through bit 63.
- R7: A store drives `mem_req_wdata` with only the low 2^size bytes of `op_store_data` (upper bytes zero). `mem_req_wstrb` is set on exactly the low 2^size bit positions, and `mem_req_write` is 1 for stores and 0 for loads.
- R8: A load asserts `wb_data_en` and `wb_base_en` together only in the cycle `mem_rsp_valid` is high. The load value goes to index `op_rt` and the new base goes to index `op_ra`.
- R9: A store never asserts `wb_data_en`. It asserts `wb_base_en` (index `op_ra`) only in the cycle its request is accepted by memory.
- R10: A load with `op_rt` equal to `op_ra` issues no request and writes no register, and `op_bad` is high for exactly the cycle after acceptance. A store with equal indices is executed normally.
- R11: `op_ready` is high only when idle. A pending request keeps `mem_req_valid` high and its address unchanged until `mem_req_ready`.
- R12: Synchronous active-high `rst` returns the unit to idle (`op_ready` high) with no request, no write-back enable and no `op_bad`, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code (R5) |
| op_signed | input | 1 | Sign-extend halfword/word loads |
| op_form | input | 2 | Offset form (R2, R3, R4) |
| op_base | input | 64 | Base register contents |
| op_offset | input | 64 | Index register or displacement field |
| op_store_data | input | 64 | Store source register contents |
| op_rt | input | 5 | Load target register index |
| op_ra | input | 5 | Base register index |
| op_bad | output | 1 | Invalid-form pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Request address |
| mem_req_size | output | 2 | Request size code |
| mem_req_wdata | output | 64 | Write data |
| mem_req_wstrb | output | 8 | Byte enables |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_rdata | input | 64 | Load data |
| wb_data_en | output | 1 | Write load value |
| wb_data_idx | output | 5 | Load value register index |
| wb_data_val | output | 64 | Extended load value |
| wb_base_en | output | 1 | Write updated base |
| wb_base_idx | output | 5 | Base register index |
| wb_base_val | output | 64 | Updated base value |

## Verification
The bench sweeps every combination of load and store, all four sizes, both signedness settings and all three offset forms. Memory stalls of zero to two cycles are used for both the request and the response.

Offsets alternate between positive and negative values and carry garbage above the displacement field. This separates the plain and scaled forms from each other and from the indexed form, and it exposes an offset wrongly added before the access. Load data alternates between values whose byte, halfword and word sign bits are set and values where they are clear, which separates zero from sign extension.

Store data with nonzero upper bytes shows whether lanes are masked. Separate runs cover the aliased-load rejection, an aliased store that must execute, and a reset arriving while a load is waiting.

// File: rtl/postinc_pkg.sv
package postinc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FORM_DISP    = 2'd0,
        FORM_SCALED  = 2'd1,
        FORM_INDEXED = 2'd2,
        FORM_INDEX_ALT = 2'd3
    } off_form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_REJECT
    } ctrl_state_e;

    typedef struct packed {
        logic      store;
        acc_size_e size;
        logic      sign;
    } op_ctl_t;

endpackage

// File: rtl/postinc_next_base.sv
module postinc_next_base
    import postinc_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int DISP_W   = 16,
    parameter int SCALED_W = 14,
    parameter int SCALE_SH = 2
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  off_form_e       form,
    output logic [XLEN-1:0] next_base
);
    localparam int SCALED_TOT = SCALED_W + SCALE_SH;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] scaled_ext;
    logic [XLEN-1:0] addend;

    // plain displacement: sign-extend the low field
    assign disp_ext = {{(XLEN-DISP_W){offset[DISP_W-1]}}, offset[DISP_W-1:0]};

    // scaled displacement: field shifted left, then sign-extended
    assign scaled_ext = {{(XLEN-SCALED_TOT){offset[SCALED_W-1]}},
                         offset[SCALED_W-1:0], {SCALE_SH{1'b0}}};

    always_comb begin
        unique case (form)
            FORM_DISP:   addend = disp_ext;
            FORM_SCALED: addend = scaled_ext;
            default:     addend = offset;
        endcase
    end

    assign next_base = base + addend;

endmodule

// File: rtl/postinc_load_ext.sv
module postinc_load_ext
    import postinc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e       size,
    input  logic            sign,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] result
);
    localparam int NSZ = $clog2(XLEN/8) + 1;

    logic [XLEN-1:0] cand_zero [NSZ];
    logic [XLEN-1:0] cand_sign [NSZ];
    logic            use_sign;

    for (genvar g = 0; g < NSZ; g++) begin : g_width
        localparam int W = 8 << g;
        if (W < XLEN) begin : g_part
            assign cand_zero[g] = {{(XLEN-W){1'b0}},     raw[W-1:0]};
            assign cand_sign[g] = {{(XLEN-W){raw[W-1]}}, raw[W-1:0]};
        end else begin : g_full
            assign cand_zero[g] = raw;
            assign cand_sign[g] = raw;
        end
    end

    // signed variants exist only between byte and full width
    assign use_sign = sign && (int'(size) != 0) && (int'(size) != NSZ-1);

    assign result = use_sign ? cand_sign[size] : cand_zero[size];

endmodule

// File: rtl/postinc_store_lane.sv
module postinc_store_lane
    import postinc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e         size,
    input  logic [XLEN-1:0]   data,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN/8-1:0] wstrb
);
    localparam int NSZ    = $clog2(XLEN/8) + 1;
    localparam int STRB_W = XLEN/8;

    logic [XLEN-1:0]   lane_data [NSZ];
    logic [STRB_W-1:0] lane_strb [NSZ];

    for (genvar g = 0; g < NSZ; g++) begin : g_lane
        localparam int W  = 8 << g;
        localparam int NB = 1 << g;
        if (W < XLEN) begin : g_part
            assign lane_data[g] = {{(XLEN-W){1'b0}}, data[W-1:0]};
            assign lane_strb[g] = {{(STRB_W-NB){1'b0}}, {NB{1'b1}}};
        end else begin : g_full
            assign lane_data[g] = data;
            assign lane_strb[g] = {STRB_W{1'b1}};
        end
    end

    assign wdata = lane_data[size];
    assign wstrb = lane_strb[size];

endmodule

// File: rtl/postinc_ctrl.sv
module postinc_ctrl
    import postinc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  logic op_store,
    input  logic op_alias,
    input  logic cur_store,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic op_ready,
    output logic capture,
    output logic op_bad,
    output logic mem_req_valid,
    output logic wb_data_en,
    output logic wb_base_en
);
    ctrl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        op_ready      = 1'b0;
        capture       = 1'b0;
        op_bad        = 1'b0;
        mem_req_valid = 1'b0;
        wb_data_en    = 1'b0;
        wb_base_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                op_ready = 1'b1;
                if (op_valid) begin
                    capture = 1'b1;
                    if (!op_store && op_alias) state_d = ST_REJECT;
                    else                       state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    if (cur_store) begin
                        wb_base_en = 1'b1;
                        state_d    = ST_IDLE;
                    end else begin
                        state_d    = ST_AWAIT;
                    end
                end
            end
            ST_AWAIT: begin
                if (mem_rsp_valid) begin
                    wb_data_en = 1'b1;
                    wb_base_en = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_REJECT: begin
                op_bad  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/postinc_ldst.sv
module postinc_ldst
    import postinc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [1:0]        op_form,
    input  logic [XLEN-1:0]   op_base,
    input  logic [XLEN-1:0]   op_offset,
    input  logic [XLEN-1:0]   op_store_data,
    input  logic [RIDX_W-1:0] op_rt,
    input  logic [RIDX_W-1:0] op_ra,
    output logic              op_bad,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    output logic [XLEN-1:0]   mem_req_wdata,
    output logic [XLEN/8-1:0] mem_req_wstrb,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_rdata,
    output logic              wb_data_en,
    output logic [RIDX_W-1:0] wb_data_idx,
    output logic [XLEN-1:0]   wb_data_val,
    output logic              wb_base_en,
    output logic [RIDX_W-1:0] wb_base_idx,
    output logic [XLEN-1:0]   wb_base_val
);
    localparam int STRB_W = XLEN/8;

    logic              capture;
    logic [XLEN-1:0]   next_base_c;
    logic [XLEN-1:0]   wdata_c;
    logic [STRB_W-1:0] wstrb_c;

    op_ctl_t           ctl_q;
    logic [XLEN-1:0]   base_q;
    logic [XLEN-1:0]   next_q;
    logic [XLEN-1:0]   wdata_q;
    logic [STRB_W-1:0] wstrb_q;
    logic [RIDX_W-1:0] rt_q;
    logic [RIDX_W-1:0] ra_q;

    postinc_next_base #(.XLEN(XLEN)) u_next (
        .base      (op_base),
        .offset    (op_offset),
        .form      (off_form_e'(op_form)),
        .next_base (next_base_c)
    );

    postinc_store_lane #(.XLEN(XLEN)) u_lane (
        .size  (acc_size_e'(op_size)),
        .data  (op_store_data),
        .wdata (wdata_c),
        .wstrb (wstrb_c)
    );

    postinc_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .op_valid      (op_valid),
        .op_store      (op_store),
        .op_alias      (op_rt == op_ra),
        .cur_store     (ctl_q.store),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .op_ready      (op_ready),
        .capture       (capture),
        .op_bad        (op_bad),
        .mem_req_valid (mem_req_valid),
        .wb_data_en    (wb_data_en),
        .wb_base_en    (wb_base_en)
    );

    // operand capture: the incremented base is settled at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            base_q  <= '0;
            next_q  <= '0;
            wdata_q <= '0;
            wstrb_q <= '0;
            rt_q    <= '0;
            ra_q    <= '0;
        end else if (capture) begin
            ctl_q   <= '{store: op_store, size: acc_size_e'(op_size), sign: op_signed};
            base_q  <= op_base;
            next_q  <= next_base_c;
            wdata_q <= wdata_c;
            wstrb_q <= wstrb_c;
            rt_q    <= op_rt;
            ra_q    <= op_ra;
        end
    end

    postinc_load_ext #(.XLEN(XLEN)) u_ext (
        .size   (ctl_q.size),
        .sign   (ctl_q.sign),
        .raw    (mem_rsp_rdata),
        .result (wb_data_val)
    );

    assign mem_req_write = ctl_q.store;
    assign mem_req_addr  = base_q;
    assign mem_req_size  = ctl_q.size;
    assign mem_req_wdata = wdata_q;
    assign mem_req_wstrb = wstrb_q;
    assign wb_data_idx   = rt_q;
    assign wb_base_idx   = ra_q;
    assign wb_base_val   = next_q;

endmodule

// File: rtl/postinc_ldst_chk.sv
module postinc_ldst_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              op_ready,
    input logic [XLEN-1:0]   op_base,
    input logic              op_bad,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [XLEN-1:0]   mem_req_addr,
    input logic [1:0]        mem_req_size,
    input logic [XLEN/8-1:0] mem_req_wstrb,
    input logic              mem_rsp_valid,
    input logic              wb_data_en,
    input logic              wb_base_en
);
    AST_ADDR_IS_OLD_BASE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid) |-> mem_req_addr == $past(op_base)); // R1

    AST_STRB_MATCHES_SIZE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> $countones(mem_req_wstrb) == (1 << mem_req_size)); // R7

    AST_LOAD_WB_PAIRED: assert property (@(posedge clk) disable iff (rst)
        wb_data_en |-> wb_base_en && mem_rsp_valid && !mem_req_valid); // R8

    AST_STORE_WB_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (wb_base_en && !wb_data_en) |-> mem_req_valid && mem_req_ready && mem_req_write); // R9

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        op_bad |-> !mem_req_valid && !wb_data_en && !wb_base_en); // R10

    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        op_bad |=> !op_bad); // R10

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !mem_req_valid && !wb_base_en && !op_bad); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)); // R11

endmodule

bind postinc_ldst postinc_ldst_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/postinc_ldst_bench.sv
module postinc_ldst_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_ready, op_store, op_signed, op_bad;
    logic [1:0]  op_size, op_form;
    logic [63:0] op_base, op_offset, op_store_data;
    logic [4:0]  op_rt, op_ra;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [63:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
    logic [1:0]  mem_req_size;
    logic [7:0]  mem_req_wstrb;
    logic        mem_rsp_valid;
    logic        wb_data_en, wb_base_en;
    logic [4:0]  wb_data_idx, wb_base_idx;
    logic [63:0] wb_data_val, wb_base_val;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    postinc_ldst u_postinc_ldst (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input logic [1:0] sz, input bit sg, input logic [1:0] fm,
                          input logic [63:0] base, input logic [63:0] off,
                          input logic [63:0] sdat, input logic [63:0] rdat,
                          input logic [4:0] rt, input logic [4:0] ra, input int lat);
        logic [63:0] nb, mk, ld;
        string ftag, ltag;
        case (fm)
            2'd0:    begin nb = base + {{48{off[15]}}, off[15:0]};        ftag = "R2"; end
            2'd1:    begin nb = base + {{48{off[13]}}, off[13:0], 2'b00}; ftag = "R3"; end
            default: begin nb = base + off;                               ftag = "R4"; end
        endcase
        mk = (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
        ld = rdat & mk;
        ltag = "R5";
        if (sg && (sz == 2'd1 || sz == 2'd2)) begin
            ltag = "R6";
            if ((sz == 2'd1 && rdat[15]) || (sz == 2'd2 && rdat[31])) ld = ld | ~mk;
        end
        @(negedge clk);
        op_valid = 1'b1; op_store = st; op_size = sz; op_signed = sg; op_form = fm;
        op_base = base; op_offset = off; op_store_data = sdat; op_rt = rt; op_ra = ra;
        #1 chk("R11", op_ready, 1);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        if (!st && rt == ra) begin
            chk("R10", op_bad, 1);
            chk("R10", mem_req_valid, 0);
            chk("R10", {wb_data_en, wb_base_en}, 0);
            @(negedge clk); #1;
            chk("R10", op_bad, 0);
            chk("R10", mem_req_valid, 0);
            return;
        end
        chk("R1", mem_req_addr, base);
        chk("R11", op_ready, 0);
        chk("R7", mem_req_write, st);
        chk("R7", mem_req_wstrb, (64'd1 << (1 << sz)) - 64'd1);
        if (st) chk("R7", mem_req_wdata, sdat & mk);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk); #1;
            chk("R11", {mem_req_valid, mem_req_addr}, {1'b1, base});
            chk("R9", wb_base_en, 0);
        end
        mem_req_ready = 1'b1;
        #1;
        if (st) begin
            chk("R9", {wb_base_en, wb_data_en}, 2'b10);
            chk(ftag, wb_base_val, nb);
            chk("R9", wb_base_idx, ra);
        end else begin
            chk("R8", {wb_base_en, wb_data_en}, 0);
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        #1 chk("R11", mem_req_valid, 0);
        if (!st) begin
            for (int k = 0; k < lat; k++) begin
                @(negedge clk); #1;
                chk("R8", {wb_base_en, wb_data_en}, 0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_rdata = rdat;
            #1;
            chk("R8", {wb_base_en, wb_data_en}, 2'b11);
            chk(ltag, wb_data_val, ld);
            chk("R8", {wb_data_idx, wb_base_idx}, {rt, ra});
            chk(ftag, wb_base_val, nb);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; op_valid = 1'b0; op_store = 1'b0; op_size = 2'd0; op_signed = 1'b0;
        op_form = 2'd0; op_base = '0; op_offset = '0; op_store_data = '0; op_rt = '0; op_ra = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
        repeat (2) @(negedge clk);
        #1;
        chk("R12", {op_ready, mem_req_valid, wb_data_en, wb_base_en, op_bad}, 5'b10000);
        @(negedge clk);
        rst = 1'b0;

        n = 0;
        for (int st = 0; st < 2; st++)
            for (int sz = 0; sz < 4; sz++)
                for (int sg = 0; sg < 2; sg++)
                    for (int fm = 0; fm < 3; fm++) begin
                        logic [63:0] base, off, sdat, rdat;
                        logic [4:0]  rt;
                        base = 64'h0000_7F00_1234_0000 + 64'(n) * 64'h1_0010_0008;
                        off  = 64'hDEAD_BEEF_0000_0000 |
                               64'(n[0] ? (16'hE0F1 + 16'(n)) : (16'h1234 + 16'(n)));
                        sdat = 64'hC3D2_E1F0_8796_A5B4 ^ (64'(n) << 8);
                        rdat = n[1] ? (64'h0123_4567_89AB_CDEF ^ 64'(n))
                                    : (64'hFEDC_BA98_7654_3210 ^ 64'(n));
                        rt   = 5'(n % 31 + 1);
                        run_op(st[0], sz[1:0], sg[0], fm[1:0], base, off, sdat, rdat,
                               rt, rt ^ 5'h10, n % 3);
                        n++;
                    end

        // alternate indexed code, signed byte and doubleword loads
        run_op(1'b0, 2'd3, 1'b1, 2'd3, 64'h10, 64'hFFFF_FFFF_FFFF_FFF0,
               '0, 64'h8000_0000_0000_0001, 5'd3, 5'd4, 1);
        run_op(1'b0, 2'd0, 1'b1, 2'd0, 64'h2000, 64'h0000_0000_0001_7FFF,
               '0, 64'h0000_0000_0000_00F5, 5'd9, 5'd8, 0);
        // aliased load rejected, aliased store executed
        run_op(1'b0, 2'd2, 1'b0, 2'd2, 64'h4000, 64'h8, '0, 64'h1, 5'd7, 5'd7, 0);
        run_op(1'b1, 2'd1, 1'b0, 2'd1, 64'h4000, 64'h3FFF, 64'hAAAA_BBBB_CCCC_DDDD,
               '0, 5'd7, 5'd7, 2);

        // reset while a load waits for its data
        @(negedge clk);
        op_valid = 1'b1; op_store = 1'b0; op_size = 2'd2; op_form = 2'd2;
        op_base = 64'h900; op_offset = 64'h4; op_rt = 5'd1; op_ra = 5'd2;
        @(negedge clk);
        op_valid = 1'b0; mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk("R12", {op_ready, mem_req_valid, wb_base_en}, 3'b100);
        mem_rsp_valid = 1'b1; mem_rsp_rdata = 64'h55;
        #1 chk("R12", {wb_data_en, wb_base_en}, 0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1 chk("R12", op_ready, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule